// File: doc/BRIEF.md
# Auto-Incrementing Work-RAM Data Port

This block gives a processor byte-wide access to a large work RAM through a small window of registers. The RAM holds more bytes than the register bus can address directly. A 17-bit pointer selects one RAM byte. Software loads the pointer one byte-wide slice at a time. It then streams data through a single data register. Every access to the data register, read or write, uses the current pointer and then moves the pointer to the next byte. A block copy therefore needs only one pointer set-up followed by repeated data accesses.

On the memory side, the block issues a request with a 24-bit address, a write flag and write data, and takes the read byte back in the same cycle. The address is the pointer placed over a fixed bank base (0x7E0000 by default). Arbitration, wait states and the RAM itself sit outside this block. Reads of the pointer registers are not supported. They return whatever byte was last carried on the register data bus, in the way an undriven bus keeps its last value.

Top module: `wram_port`

## Requirements
- R1: After reset the pointer is zero and the retained bus byte is zero.
- R2: A write with regSel=1 replaces pointer bits 7:0 with the written byte and leaves bits 16:8 unchanged.
- R3: A write with regSel=2 replaces pointer bits 15:8 with the written byte and leaves bits 7:0 and bit 16 unchanged.
- R4: A write with regSel=3 replaces only pointer bit 16, taken from data bit 0. Data bits 7:1 have no effect.
- R5: While memReq is high, memAddr equals 0x7E0000 ORed with the 17-bit pointer.
- R6: A read with regSel=0 raises memReq with memWe low in the same cycle, returns memRdata on regRdata in that cycle, and advances the pointer by one at the closing clock edge.
- R7: A write with regSel=0 raises memReq with memWe high and memWdata equal to regWdata in the same cycle, and advances the pointer by one at the closing clock edge.
- R8: Advancing the pointer from 0x1FFFF gives 0x00000.
- R9: Data accesses in consecutive cycles reach consecutive addresses, with no idle cycle needed between them.
- R10: A read with regSel of 1, 2 or 3 issues no memory request and leaves the pointer unchanged. It returns the last byte carried on the bus, which is the data of the most recent register write or of the most recent data-register read.
- R11: If regWr and regRd are both high in one cycle, the access is treated as a write only.
- R12: With neither strobe high, memReq is low and the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regSel | input | 2 | Register select: 0 data, 1 pointer low, 2 pointer middle, 3 pointer high |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 24 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid in the request cycle |

## Verification
The assertions assume that each strobe lasts exactly one cycle per access. They also assume that memRdata is valid in the cycle of the request, so that a read completes at the edge that ends its cycle. The bench drives the strobes after the falling edge and drops them after each rising edge. It serves memory reads from an arithmetic function of the address, so no access ever stalls. Every pointer value that the bench predicts comes from its own pointer model, which is updated per access. The bench sweeps all 256 data values through each slice register.

// File: rtl/wram_port_pkg.sv
package wram_port_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_LO   = 2'd1,
    SEL_MID  = 2'd2,
    SEL_HI   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ldLo;
    logic ldMid;
    logic ldHi;
    logic step;
    logic memRd;
    logic memWr;
    logic anyWr;
  } ctlStrobes_t;

endpackage

// File: rtl/wram_port_ctl.sv
module wram_port_ctl
  import wram_port_pkg::*;
(
  input  logic [1:0]  regSel,
  input  logic        regWr,
  input  logic        regRd,
  output ctlStrobes_t ctl
);

  logic wrEff;
  logic rdEff;
  logic selData;

  always_comb begin
    wrEff   = regWr;
    rdEff   = regRd & ~regWr;
    selData = (regSel == SEL_DATA);

    ctl       = '0;
    ctl.anyWr = wrEff;
    ctl.ldLo  = wrEff & (regSel == SEL_LO);
    ctl.ldMid = wrEff & (regSel == SEL_MID);
    ctl.ldHi  = wrEff & (regSel == SEL_HI);
    ctl.memWr = wrEff & selData;
    ctl.memRd = rdEff & selData;
    ctl.step  = (wrEff | rdEff) & selData;
  end

endmodule

// File: rtl/wram_port_dp.sv
module wram_port_dp
  import wram_port_pkg::*;
#(
  parameter int PTR_W  = 17,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BANK_BASE = 24'h7E0000
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] regRdata
);

  localparam int HI_LSB = 2 * DATA_W;
  localparam int HI_W   = PTR_W - HI_LSB;

  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  ptrNext;
  logic [DATA_W-1:0] busHold;

  always_comb begin
    ptrNext = ptr;
    if (ctl.ldLo)  ptrNext[DATA_W-1:0] = regWdata;
    if (ctl.ldMid) ptrNext[HI_LSB-1:DATA_W] = regWdata;
    if (ctl.ldHi)  ptrNext[PTR_W-1:HI_LSB] = regWdata[HI_W-1:0];
    if (ctl.step)  ptrNext = ptr + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      busHold <= '0;
    end else begin
      ptr <= ptrNext;
      if (ctl.anyWr)      busHold <= regWdata;
      else if (ctl.memRd) busHold <= memRdata;
    end
  end

  assign memReq   = ctl.memRd | ctl.memWr;
  assign memWe    = ctl.memWr;
  assign memAddr  = BANK_BASE | ADDR_W'(ptr);
  assign memWdata = regWdata;
  assign regRdata = ctl.memRd ? memRdata : busHold;

  // R6 R7 R9
  step_advance_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.step |=> ptr == PTR_W'($past(ptr) + PTR_W'(1)));

  // R8
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.step && ptr == {PTR_W{1'b1}}) |=> ptr == '0);

  // R2
  lo_load_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.ldLo |=> ptr[PTR_W-1:DATA_W] == $past(ptr[PTR_W-1:DATA_W]));

  // R3
  mid_load_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.ldMid |=> (ptr[DATA_W-1:0] == $past(ptr[DATA_W-1:0]))
               && (ptr[PTR_W-1:HI_LSB] == $past(ptr[PTR_W-1:HI_LSB])));

  // R4
  hi_load_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.ldHi |=> ptr[HI_LSB-1:0] == $past(ptr[HI_LSB-1:0]));

  // R10 R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl.step || ctl.ldLo || ctl.ldMid || ctl.ldHi) |=> $stable(ptr));

  // R5
  addr_base_chk: assert property (@(posedge clk) disable iff (rst)
    memReq |-> (memAddr & ~BANK_BASE) == ADDR_W'(ptr) || BANK_BASE[PTR_W-1:0] != '0);

endmodule

// File: rtl/wram_port.sv
module wram_port
  import wram_port_pkg::*;
#(
  parameter int PTR_W  = 17,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BANK_BASE = 24'h7E0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  ctlStrobes_t ctl;

  wram_port_ctl u_ctl (
    .regSel (regSel),
    .regWr  (regWr),
    .regRd  (regRd),
    .ctl    (ctl)
  );

  wram_port_dp #(
    .PTR_W     (PTR_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BANK_BASE (BANK_BASE)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .regWdata (regWdata),
    .memRdata (memRdata),
    .memReq   (memReq),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .regRdata (regRdata)
  );

  // R11
  dual_strobe_write_chk: assert property (@(posedge clk) disable iff (rst)
    (regWr && regRd && regSel == SEL_DATA) |-> memReq && memWe);

  // R12
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!regWr && !regRd) |-> !memReq);

endmodule

// File: tb/wram_port_tb.sv
module wram_port_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  regSel = 2'd0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [7:0]  regWdata = 8'd0;
  logic [7:0]  regRdata;
  logic        memReq;
  logic        memWe;
  logic [23:0] memAddr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [16:0] mPtr;
  logic [7:0]  mBus;

  logic        sReq, sWe;
  logic [23:0] sAddr;
  logic [7:0]  sWdata, sRdata;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] memFn(input logic [16:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ (a[16] ? 8'hA5 : 8'h00);
  endfunction

  assign memRdata = memFn(memAddr[16:0]);

  wram_port u_dut (
    .clk(clk), .rst(rst), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] sel, input logic wr, input logic rd, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWr = wr; regRd = rd; regWdata = d;
    #(CLK_P/4);
    sReq = memReq; sWe = memWe; sAddr = memAddr; sWdata = memWdata; sRdata = regRdata;
    @(posedge clk);
    #1;
    regWr = 1'b0; regRd = 1'b0;
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] d);
    cyc(sel, 1'b1, 1'b0, d);
    mBus = d;
    case (sel)
      2'd1: mPtr[7:0]  = d;
      2'd2: mPtr[15:8] = d;
      2'd3: mPtr[16]   = d[0];
      default: mPtr = mPtr + 17'd1;
    endcase
  endtask

  task automatic dataRead(input string tag);
    logic [23:0] eAddr;
    eAddr = 24'h7E0000 | {7'd0, mPtr};
    cyc(2'd0, 1'b0, 1'b1, 8'h00);
    chk(sReq && !sWe, tag, {30'd0, sReq, sWe}, 32'h2);
    chk(sAddr == eAddr, tag, sAddr, eAddr);
    chk(sRdata == memFn(mPtr), tag, sRdata, memFn(mPtr));
    mBus = memFn(mPtr);
    mPtr = mPtr + 17'd1;
  endtask

  task automatic setPtr(input logic [16:0] p);
    wrReg(2'd1, p[7:0]);
    wrReg(2'd2, p[15:8]);
    wrReg(2'd3, {7'h55, p[16]});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mPtr = '0; mBus = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 R10: retained bus byte is zero, no request on a pointer-register read
    cyc(2'd1, 1'b0, 1'b1, 8'h00);
    chk(sRdata == 8'h00, "R1 bus byte", sRdata, 8'h00);
    chk(!sReq, "R10 no req", sReq, 0);
    // R1 R5 R6: pointer starts at zero
    dataRead("R1 R5 R6 first read");

    // R12: idle cycle
    cyc(2'd0, 1'b0, 1'b0, 8'hFF);
    chk(!sReq, "R12 idle", sReq, 0);

    // R2: sweep low slice
    setPtr(17'h1C300);
    for (int v = 0; v < 256; v++) begin
      wrReg(2'd1, v[7:0]);
      dataRead("R2 lo sweep");
    end

    // R3: sweep middle slice
    setPtr(17'h0007E);
    for (int v = 0; v < 256; v++) begin
      wrReg(2'd2, v[7:0]);
      dataRead("R3 mid sweep");
    end

    // R4: sweep high slice data, only bit 0 counts
    setPtr(17'h0A5F0);
    for (int v = 0; v < 256; v++) begin
      wrReg(2'd3, v[7:0]);
      dataRead("R4 hi sweep");
    end

    // R7: data writes
    setPtr(17'h1FFC0);
    for (int v = 0; v < 48; v++) begin
      logic [23:0] eAddr;
      logic [7:0]  d;
      eAddr = 24'h7E0000 | {7'd0, mPtr};
      d = 8'(v * 37 + 11);
      wrReg(2'd0, d);
      chk(sReq && sWe, "R7 write req", {30'd0, sReq, sWe}, 32'h3);
      chk(sAddr == eAddr, "R7 write addr", sAddr, eAddr);
      chk(sWdata == d, "R7 write data", sWdata, d);
    end

    // R8: wrap
    setPtr(17'h1FFFF);
    dataRead("R8 at top");
    chk(mPtr == 17'd0, "R8 model", mPtr, 0);
    dataRead("R8 after wrap");

    // R9: back-to-back stream across a slice boundary
    setPtr(17'h0FF80);
    for (int i = 0; i < 600; i++) dataRead("R9 stream");

    // R10: pointer-register reads return the last bus byte and keep the pointer
    wrReg(2'd0, 8'h3C);
    cyc(2'd2, 1'b0, 1'b1, 8'h00);
    chk(sRdata == 8'h3C, "R10 after write", sRdata, 8'h3C);
    chk(!sReq, "R10 no req mid", sReq, 0);
    dataRead("R10 read");
    cyc(2'd3, 1'b0, 1'b1, 8'h00);
    chk(sRdata == mBus, "R10 after data read", sRdata, mBus);
    dataRead("R10 pointer kept");

    // R11: both strobes give a single write
    begin
      logic [23:0] eAddr;
      eAddr = 24'h7E0000 | {7'd0, mPtr};
      cyc(2'd0, 1'b1, 1'b1, 8'h9E);
      chk(sReq && sWe, "R11 write wins", {30'd0, sReq, sWe}, 32'h3);
      chk(sAddr == eAddr, "R11 addr", sAddr, eAddr);
      chk(sWdata == 8'h9E, "R11 data", sWdata, 8'h9E);
      mBus = 8'h9E;
      mPtr = mPtr + 17'd1;
      dataRead("R11 single step");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule